// File: doc/BRIEF.md
# Five-Digit Multiplexed Display Scanner

This block lights five seven-segment digits one at a time, fast enough that the eye sees all five at once. Three of the digits show a target number. They share one parallel 4-bit BCD bus, and a one-hot group of three enables picks which one is lit. The other two digits show a score. Their values do not travel on the bus. For each score digit the block builds a byte and bit-bangs it into an external 8-bit serial-in, parallel-out register. The lower nibble of that register feeds a BCD decoder, and the two score digits have their own one-hot pair of enables. Segment decoding and the external shift register are not part of this block.

The scanner visits the digits in a fixed rotation: target hundreds, target tens, target ones, score ones, score tens, then back to the start. All five input digits are copied into a snapshot at the start of every rotation. A change that arrives in the middle of a rotation therefore never mixes old and new digits. Each digit stays lit for a parameterised number of clock cycles. Every enable is off while the bus is being updated or a byte is being shifted out, so no digit ever shows a half-written value. The serial clock comes from a parameterised divider.

Top module: `seg_scan_mux`

## Requirements
- R1: At most one bit of `tgt_en_o` is high in any cycle. Bit 2 lights hundreds, bit 1 tens and bit 0 ones, and the lit digit's snapshot value is on `bcd_o`.
- R2: Every digit stays lit for exactly `HOLD_CYC` consecutive clock cycles.
- R3: Digits light in the order target hundreds, target tens, target ones, score ones, score tens, and the order then repeats.
- R4: Each score transfer carries one byte, most significant bit first, with exactly eight serial clock rises. The upper nibble is zero and the lower nibble is the score digit.
- R5: The latch goes low before the first serial clock rise and rises only after the eighth bit. `ser_data_o` changes only while `ser_clk_o` is low, and `ser_clk_o` rises only while the latch is low.
- R6: At most one bit of `sc_en_o` is high (bit 0 score ones, bit 1 score tens), and no score enable is ever high together with a target enable.
- R7: All enables are off while the latch is low and for at least one cycle between two lit digits, and `bcd_o` is stable while a target digit is lit.
- R8: Input digits are sampled once per rotation, when target hundreds is loaded; input changes during a rotation show up only in the next rotation.
- R9: Every high or low phase of `ser_clk_o` lasts at least `SCLK_DIV` clock cycles.
- R10: While `rst` is high, all enables are off, the latch is high, the serial clock and data are low and `bcd_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_hun_i | input | 4 | Target hundreds digit, BCD |
| tgt_ten_i | input | 4 | Target tens digit, BCD |
| tgt_one_i | input | 4 | Target ones digit, BCD |
| sc_one_i | input | 4 | Score ones digit, BCD |
| sc_ten_i | input | 4 | Score tens digit, BCD |
| bcd_o | output | 4 | Shared BCD bus for the target digits |
| tgt_en_o | output | 3 | One-hot target enables (2 hundreds, 1 tens, 0 ones) |
| sc_en_o | output | 2 | One-hot score enables (0 ones, 1 tens) |
| ser_data_o | output | 1 | Serial data to the external shift register |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_latch_o | output | 1 | Output latch of the external register, low during a transfer |

## Verification
Two things happen in the same LOAD cycle of target hundreds: the five-digit snapshot is captured, and the hundreds value goes onto the bus straight from the input. To provoke this, the bench changes every input in the dark cycle just after score tens goes dark. It then expects all five digits of the next rotation to carry the new values. A second collision comes from changing the inputs right after hundreds is shown. The bench judges that case by requiring the rest of the rotation, including both serially shifted score bytes, to keep the old values.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int NUM_DIG    = 5;
  localparam int NUM_TGT    = 3;
  localparam int NUM_SC     = 2;
  localparam int BCD_W      = 4;
  localparam int SER_W      = 8;
  localparam int SER_STEPS  = 2 * SER_W + 2;
  localparam int SER_STEP_W = $clog2(SER_STEPS);

  typedef enum logic [2:0] {
    SL_T_HUN = 3'd0,
    SL_T_TEN = 3'd1,
    SL_T_ONE = 3'd2,
    SL_S_ONE = 3'd3,
    SL_S_TEN = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_PRIME,
    ST_SHIFT,
    ST_HOLD
  } phase_e;

  typedef struct packed {
    logic latch;
    logic sck;
    logic sd;
  } ser_lines_t;

  function automatic slot_e next_slot(slot_e s);
    return (s == SL_S_TEN) ? SL_T_HUN : slot_e'(s + 3'd1);
  endfunction

  function automatic logic is_target(slot_e s);
    return s < SL_S_ONE;
  endfunction

  function automatic logic [SER_W-1:0] pack_score(logic [BCD_W-1:0] d);
    return {{(SER_W-BCD_W){1'b0}}, d};
  endfunction

  // step 0: latch low; odd steps: clock low with data; even steps: clock high;
  // last step: latch high again
  function automatic ser_lines_t ser_step(logic active, logic [SER_STEP_W-1:0] step,
                                          logic [SER_W-1:0] b);
    ser_lines_t l;
    int k;
    l = '{latch: 1'b1, sck: 1'b0, sd: 1'b0};
    if (active) begin
      if (step == '0) begin
        l.latch = 1'b0;
      end else if (int'(step) < SER_STEPS - 1) begin
        k       = SER_W - 1 - ((int'(step) - 1) >> 1);
        l.latch = 1'b0;
        l.sck   = ~step[0];
        l.sd    = b[k];
      end
    end
    return l;
  endfunction

endpackage

// File: rtl/seg_ser_shifter.sv
module seg_ser_shifter
  import seg_scan_pkg::*;
#(
  parameter int SCLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SER_W-1:0] byte_i,
  output logic             done_o,
  output logic             ser_data_o,
  output logic             ser_clk_o,
  output logic             ser_latch_o
);

  localparam int DIV_W = $clog2(SCLK_DIV + 1);
  localparam logic [SER_STEP_W-1:0] LAST_STEP = SER_STEP_W'(SER_STEPS - 1);
  localparam logic [DIV_W-1:0]      DIV_TOP   = DIV_W'(SCLK_DIV - 1);

  logic                  busy;
  logic [SER_STEP_W-1:0] step;
  logic [DIV_W-1:0]      dcnt;
  logic [SER_W-1:0]      shreg;
  logic                  step_end;
  ser_lines_t            lines;

  assign step_end = busy && (dcnt == DIV_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= '0;
      dcnt   <= '0;
      shreg  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy  <= 1'b1;
        step  <= '0;
        dcnt  <= '0;
        shreg <= byte_i;
      end else if (step_end) begin
        dcnt <= '0;
        if (step == LAST_STEP) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else if (busy) begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign lines       = ser_step(busy, step, shreg);
  assign ser_data_o  = lines.sd;
  assign ser_clk_o   = lines.sck;
  assign ser_latch_o = lines.latch;

  AST_CLK_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk_o) |-> !ser_latch_o);  // R5
  AST_DATA_STILL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));  // R5
  AST_DONE_LATCHED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ser_latch_o);  // R5

endmodule

// File: rtl/seg_scan_seq.sv
module seg_scan_seq
  import seg_scan_pkg::*;
#(
  parameter int HOLD_CYC = 50000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_DIG-1:0][BCD_W-1:0]  dig_i,
  input  logic                           ser_done_i,
  output slot_e                          slot_o,
  output logic                           lit_o,
  output logic [BCD_W-1:0]               bus_o,
  output logic                           ser_start_o,
  output logic [SER_W-1:0]               ser_byte_o
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_CYC - 1);

  phase_e                         st;
  slot_e                          slot;
  logic [CNT_W-1:0]               cnt;
  logic [NUM_DIG-1:0][BCD_W-1:0]  snap;
  logic [BCD_W-1:0]               cur_dig;
  logic                           snap_take;

  assign snap_take = (st == ST_LOAD) && (slot == SL_T_HUN);
  assign cur_dig   = (slot == SL_T_HUN) ? dig_i[0] : snap[slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_LOAD;
      slot  <= SL_T_HUN;
      cnt   <= '0;
      bus_o <= '0;
      snap  <= '0;
    end else begin
      unique case (st)
        ST_LOAD: begin
          if (snap_take) snap <= dig_i;
          if (is_target(slot)) begin
            bus_o <= cur_dig;
            st    <= ST_PRIME;
          end else begin
            st <= ST_SHIFT;
          end
        end
        ST_PRIME: begin
          cnt <= '0;
          st  <= ST_HOLD;
        end
        ST_SHIFT: begin
          cnt <= '0;
          if (ser_done_i) st <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt == CNT_TOP) begin
            cnt  <= '0;
            slot <= next_slot(slot);
            st   <= ST_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  assign slot_o      = slot;
  assign lit_o       = (st == ST_HOLD);
  assign ser_start_o = (st == ST_LOAD) && !is_target(slot);
  assign ser_byte_o  = pack_score(snap[slot]);

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !snap_take |=> $stable(snap));  // R8
  AST_BUS_QUIET_LIT: assert property (@(posedge clk) disable iff (rst)
    lit_o |-> $stable(bus_o));  // R7
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot) |-> $past(lit_o));  // R3

endmodule

// File: rtl/seg_scan_mux.sv
module seg_scan_mux
  import seg_scan_pkg::*;
#(
  parameter int HOLD_CYC = 50000,
  parameter int SCLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] tgt_hun_i,
  input  logic [3:0] tgt_ten_i,
  input  logic [3:0] tgt_one_i,
  input  logic [3:0] sc_one_i,
  input  logic [3:0] sc_ten_i,
  output logic [3:0] bcd_o,
  output logic [2:0] tgt_en_o,
  output logic [1:0] sc_en_o,
  output logic       ser_data_o,
  output logic       ser_clk_o,
  output logic       ser_latch_o
);

  logic [NUM_DIG-1:0][BCD_W-1:0] dig;
  slot_e                         slot;
  logic                          lit;
  logic                          ser_start;
  logic                          ser_done;
  logic [SER_W-1:0]              ser_byte;

  assign dig = {sc_ten_i, sc_one_i, tgt_one_i, tgt_ten_i, tgt_hun_i};

  seg_scan_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .dig_i       (dig),
    .ser_done_i  (ser_done),
    .slot_o      (slot),
    .lit_o       (lit),
    .bus_o       (bcd_o),
    .ser_start_o (ser_start),
    .ser_byte_o  (ser_byte)
  );

  seg_ser_shifter #(.SCLK_DIV(SCLK_DIV)) u_ser (
    .clk         (clk),
    .rst         (rst),
    .start_i     (ser_start),
    .byte_i      (ser_byte),
    .done_o      (ser_done),
    .ser_data_o  (ser_data_o),
    .ser_clk_o   (ser_clk_o),
    .ser_latch_o (ser_latch_o)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt_en
    assign tgt_en_o[g] = lit && (slot == slot_e'(3'(NUM_TGT - 1 - g)));
  end

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc_en
    assign sc_en_o[g] = lit && (slot == slot_e'(3'(NUM_TGT + g)));
  end

  AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_en_o));  // R1
  AST_SC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sc_en_o) && !((|tgt_en_o) && (|sc_en_o)));  // R6
  AST_DARK_DURING_LATCH: assert property (@(posedge clk) disable iff (rst)
    !ser_latch_o |-> (tgt_en_o == '0 && sc_en_o == '0));  // R7
  AST_BUS_STABLE_LIT: assert property (@(posedge clk) disable iff (rst)
    (|tgt_en_o) |-> $stable(bcd_o));  // R7

endmodule

// File: tb/seg_scan_mux_tb.sv
module seg_scan_mux_tb;

  localparam int H = 12;
  localparam int D = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] hun_i = 0, ten_i = 0, one_i = 0, so_i = 0, st_i = 0;
  logic [3:0] bcd;
  logic [2:0] tgt_en;
  logic [1:0] sc_en;
  logic       sd, sck, lat;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  seg_scan_mux #(.HOLD_CYC(H), .SCLK_DIV(D)) u_dut (
    .clk(clk), .rst(rst),
    .tgt_hun_i(hun_i), .tgt_ten_i(ten_i), .tgt_one_i(one_i),
    .sc_one_i(so_i), .sc_ten_i(st_i),
    .bcd_o(bcd), .tgt_en_o(tgt_en), .sc_en_o(sc_en),
    .ser_data_o(sd), .ser_clk_o(sck), .ser_latch_o(lat)
  );

  // digit fields: [19:16] hundreds [15:12] tens [11:8] ones [7:4] score ones [3:0] score tens
  localparam logic [19:0] VEC [0:5] = '{
    20'h25509, 20'h00000, 20'h99999, 20'h12345, 20'h98765, 20'h70381
  };

  // independent serial decoder
  logic       p_sck = 0, p_lat = 1, p_sd = 0;
  logic [7:0] mon_sh = 0, last_byte = 0;
  int         nbits = 0, last_bits = 0, wid = 0, viol5 = 0, viol9 = 0;

  always @(negedge clk) begin
    if (rst) begin
      p_sck = 0; p_lat = 1; p_sd = 0; nbits = 0; wid = 0;
    end else begin
      if (sck != p_sck) begin
        if (wid < D) viol9++;
        wid = 1;
      end else wid++;
      if (sck && !p_sck) begin
        if (lat) viol5++;
        mon_sh = {mon_sh[6:0], sd};
        nbits++;
      end
      if (sck && p_sck && sd != p_sd) viol5++;
      if (!lat && p_lat && sck) viol5++;
      if (lat && !p_lat) begin
        last_byte = mon_sh; last_bits = nbits; nbits = 0;
      end
      p_sck = sck; p_lat = lat; p_sd = sd;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [19:0] v);
    {hun_i, ten_i, one_i, so_i, st_i} = v;
  endtask

  task automatic get_digit(output logic [4:0] en, output logic [3:0] val,
                           output int len, output bit dark_after, output bit stable);
    logic [4:0] cur;
    cur = {tgt_en, sc_en};
    while (cur == 0) begin
      @(negedge clk);
      cur = {tgt_en, sc_en};
    end
    en = cur; val = bcd; len = 0; stable = 1;
    while ({tgt_en, sc_en} == en) begin
      len++;
      if (bcd != val) stable = 0;
      @(negedge clk);
    end
    dark_after = ({tgt_en, sc_en} == 5'b0);
  endtask

  localparam logic [4:0] EXP_EN [0:4] = '{5'b10000, 5'b01000, 5'b00100, 5'b00001, 5'b00010};

  task automatic check_digits(input logic [19:0] v, input int first, input int last);
    logic [4:0] en; logic [3:0] val; int len; bit dk, stb; logic [3:0] d;
    for (int k = first; k <= last; k++) begin
      get_digit(en, val, len, dk, stb);
      d = v[19-4*k -: 4];
      check(en == EXP_EN[k], "R3 order", en, EXP_EN[k]);
      check(len == H, "R2 hold", len, H);
      check(dk, "R7 dark gap", dk, 1);
      if (k < 3) begin
        check(val == d, "R1/R8 bus value", val, d);
        check(stb, "R7 bus stable", stb, 1);
      end else begin
        check(last_byte == {4'h0, d}, "R4 byte", last_byte, {4'h0, d});
        check(last_bits == 8, "R4 bit count", last_bits, 8);
        check(viol5 == 0, "R5 framing", viol5, 0);
        check(viol9 == 0, "R9 phase width", viol9, 0);
        check(k == 3 ? sc_en == 0 : 1'b1, "R6 score group", sc_en, 0);
      end
    end
  endtask

  initial begin
    apply(VEC[0]);
    repeat (4) @(negedge clk);
    // R10 reset state
    check(tgt_en == 0 && sc_en == 0, "R10 enables", {tgt_en, sc_en}, 0);
    check(lat == 1 && sck == 0 && sd == 0, "R10 serial", {lat, sck, sd}, 3'b100);
    check(bcd == 0, "R10 bus", bcd, 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      apply(VEC[i]);
      check_digits(VEC[i], 0, 4);
    end
    // R8 mid-scan change: rest of rotation keeps old values
    apply(20'h31415);
    check_digits(20'h31415, 0, 0);
    apply(20'h86420);
    check_digits(20'h31415, 1, 4);
    check_digits(20'h86420, 0, 4);
    // R3 wrap: another rotation with unchanged inputs
    check_digits(20'h86420, 0, 4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule